// File: doc/BRIEF.md
# Byte Matrix Multiply-Accumulate Unit

This unit takes three 128-bit operands in one request. The left operand is a 2x8 matrix of bytes and the right operand is an 8x2 matrix of bytes. The accumulator operand is a 2x2 matrix of 32-bit words. The unit forms the 2x2 product of the two byte matrices and adds it to the accumulator. Each output word is the matching accumulator word plus an eight-term dot product of one left row with one right column.

A two-bit mode sets how the bytes are read. Both operands can be two's complement, both can be unsigned, or the left operand can be unsigned while the right one is signed. The fourth code is reserved. A request with that code produces a flagged result that carries the accumulator through unchanged.

The unit accepts a new request on every cycle while `in_ready` is high. The result appears after a fixed two-stage pipeline.

Top module: `imm_mac`

## Requirements
- R1: Layout. Byte n of an operand sits in bits 8n+7..8n, and byte 0 is least significant. Bytes 8i..8i+7 of `src_a` form row i, and bytes 8j..8j+7 of `src_b` form column j. Element (i,j) is returned in bits 32(2i+j)+31..32(2i+j) of `out_data`, and uses the accumulator word at the same position of `acc_in`.
- R2: Mode 2'b00 reads every byte of both operands as two's complement.
- R3: Mode 2'b01 reads every byte of both operands as unsigned.
- R4: Mode 2'b10 zero-extends the `src_a` bytes and sign-extends the `src_b` bytes.
- R5: Each output word is computed modulo 2^32, with no saturation in either direction.
- R6: A request accepted with mode 2'b11 returns `out_illegal` high together with `out_valid`, and `out_data` equal to that request's `acc_in`.
- R7: A request is accepted at a rising edge where `in_valid` and `in_ready` are both high. Its result is on the outputs after the second rising edge that follows, and requests on consecutive cycles give results on consecutive cycles.
- R8: `out_valid` is high only for accepted requests, and `out_illegal` stays low for the results of legal modes.
- R9: While `rst_n` is low, `out_valid`, `out_illegal` and `in_ready` are low, even when the pipeline was full. `in_ready` rises at the first clock edge after reset is released.
- R10: `out_illegal` is never high while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| mode | input | 2 | Byte interpretation code |
| src_a | input | 128 | Left matrix, 2 rows of 8 bytes |
| src_b | input | 128 | Right matrix, 2 columns of 8 bytes |
| acc_in | input | 128 | Accumulator, four 32-bit words |
| out_valid | output | 1 | Result present |
| out_illegal | output | 1 | Result came from the reserved mode |
| out_data | output | 128 | Four 32-bit sums |

## Verification
Each fault in stage state has a distinct signature at the ports, always exactly two cycles after the request that caused it:
- A dropped or duplicated stage-one valid shows up as a missing or extra `out_valid`.
- A stale captured operand gives a wrong word in one lane.
- A wrong extension choice changes the sums only when the top bit of a byte is set, so the stimulus loads high bytes heavily.
- A lost bypass flag returns a sum where the accumulator should pass through.

A reference model in the bench is compared on every cycle. It covers all three legal modes with back-to-back requests and gaps, extreme byte values that force wrap-around in both directions, reserved-mode requests placed between legal ones, and a reset that arrives while the pipeline is full.

// File: rtl/imm_pkg.sv
package imm_pkg;

  typedef enum logic [1:0] {
    MODE_SS  = 2'b00,
    MODE_UU  = 2'b01,
    MODE_US  = 2'b10,
    MODE_BAD = 2'b11
  } mac_mode_e;

endpackage

// File: rtl/imm_mode_dec.sv
module imm_mode_dec
  import imm_pkg::*;
(
  input  logic [1:0] mode,
  output logic       a_uns,
  output logic       b_uns,
  output logic       bad
);

  mac_mode_e md;
  assign md = mac_mode_e'(mode);

  always_comb begin
    a_uns = 1'b0;
    b_uns = 1'b0;
    bad   = 1'b0;
    case (md)
      MODE_SS:  begin a_uns = 1'b0; b_uns = 1'b0; end
      MODE_UU:  begin a_uns = 1'b1; b_uns = 1'b1; end
      MODE_US:  begin a_uns = 1'b1; b_uns = 1'b0; end
      default:  bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/imm_dot8.sv
module imm_dot8 #(
  parameter int ELEM_W = 8,
  parameter int TERMS  = 8,
  parameter int DOT_W  = 2 * (ELEM_W + 1) + $clog2(TERMS)
) (
  input  logic [TERMS*ELEM_W-1:0] a_vec,
  input  logic [TERMS*ELEM_W-1:0] b_vec,
  input  logic                    a_uns,
  input  logic                    b_uns,
  output logic signed [DOT_W-1:0] dot
);

  localparam int EXT_W  = ELEM_W + 1;
  localparam int PROD_W = 2 * EXT_W;

  logic signed [EXT_W-1:0]  ax   [TERMS];
  logic signed [EXT_W-1:0]  bx   [TERMS];
  logic signed [PROD_W-1:0] prod [TERMS];

  for (genvar k = 0; k < TERMS; k++) begin : g_term
    assign ax[k]   = $signed({~a_uns & a_vec[k*ELEM_W+ELEM_W-1], a_vec[k*ELEM_W +: ELEM_W]});
    assign bx[k]   = $signed({~b_uns & b_vec[k*ELEM_W+ELEM_W-1], b_vec[k*ELEM_W +: ELEM_W]});
    assign prod[k] = ax[k] * bx[k];
  end

  always_comb begin
    dot = '0;
    for (int k = 0; k < TERMS; k++) begin
      dot = dot + DOT_W'(prod[k]);
    end
  end

endmodule

// File: rtl/imm_lane_add.sv
module imm_lane_add #(
  parameter int ACC_W = 32,
  parameter int DOT_W = 21
) (
  input  logic [ACC_W-1:0]        acc,
  input  logic signed [DOT_W-1:0] dot,
  input  logic                    bypass,
  output logic [ACC_W-1:0]        res
);

  logic [ACC_W-1:0] dot_ext;
  assign dot_ext = {{(ACC_W-DOT_W){dot[DOT_W-1]}}, dot};

  always_comb begin
    if (bypass) res = acc;
    else        res = acc + dot_ext;
  end

endmodule

// File: rtl/imm_mac.sv
module imm_mac
  import imm_pkg::*;
#(
  parameter int ELEM_W = 8,
  parameter int DIM_K  = 8,
  parameter int ROWS   = 2,
  parameter int COLS   = 2,
  parameter int ACC_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [1:0]                    mode,
  input  logic [ROWS*DIM_K*ELEM_W-1:0]  src_a,
  input  logic [COLS*DIM_K*ELEM_W-1:0]  src_b,
  input  logic [ROWS*COLS*ACC_W-1:0]    acc_in,
  output logic                          out_valid,
  output logic                          out_illegal,
  output logic [ROWS*COLS*ACC_W-1:0]    out_data
);

  localparam int VEC_W = DIM_K * ELEM_W;
  localparam int LANES = ROWS * COLS;
  localparam int OUT_W = LANES * ACC_W;
  localparam int DOT_W = 2 * (ELEM_W + 1) + $clog2(DIM_K);

  // decode and stage-one datapath
  logic a_uns, b_uns, bad;
  logic accept;
  logic signed [DOT_W-1:0] dot [LANES];

  imm_mode_dec u_dec (
    .mode  (mode),
    .a_uns (a_uns),
    .b_uns (b_uns),
    .bad   (bad)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      imm_dot8 #(
        .ELEM_W (ELEM_W),
        .TERMS  (DIM_K),
        .DOT_W  (DOT_W)
      ) u_dot (
        .a_vec (src_a[r*VEC_W +: VEC_W]),
        .b_vec (src_b[c*VEC_W +: VEC_W]),
        .a_uns (a_uns),
        .b_uns (b_uns),
        .dot   (dot[r*COLS+c])
      );
    end
  end

  // stage-one registers
  logic rdy_q, rdy_d;
  logic s1_vld_q, s1_vld_d;
  logic s1_bad_q;
  logic signed [DOT_W-1:0] s1_dot_q [LANES];
  logic [OUT_W-1:0] s1_acc_q;

  assign in_ready = rdy_q;
  assign accept   = in_valid & rdy_q;

  always_comb begin
    rdy_d    = 1'b1;
    s1_vld_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      s1_vld_q <= 1'b0;
    end else begin
      rdy_q    <= rdy_d;
      s1_vld_q <= s1_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_bad_q <= bad;
      s1_dot_q <= dot;
      s1_acc_q <= acc_in;
    end
  end

  // stage-two accumulate
  logic [OUT_W-1:0] sum_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    imm_lane_add #(
      .ACC_W (ACC_W),
      .DOT_W (DOT_W)
    ) u_add (
      .acc    (s1_acc_q[l*ACC_W +: ACC_W]),
      .dot    (s1_dot_q[l]),
      .bypass (s1_bad_q),
      .res    (sum_d[l*ACC_W +: ACC_W])
    );
  end

  logic out_vld_q, out_vld_d;
  logic out_bad_q, out_bad_d;
  logic [OUT_W-1:0] out_data_q;

  always_comb begin
    out_vld_d = s1_vld_q;
    out_bad_d = s1_vld_q & s1_bad_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q <= 1'b0;
      out_bad_q <= 1'b0;
    end else begin
      out_vld_q <= out_vld_d;
      out_bad_q <= out_bad_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_vld_q) begin
      out_data_q <= sum_d;
    end
  end

  assign out_valid   = out_vld_q;
  assign out_illegal = out_bad_q;
  assign out_data    = out_data_q;

endmodule

// File: rtl/imm_mac_chk.sv
module imm_mac_chk #(
  parameter int OUT_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       mode,
  input logic [OUT_W-1:0] acc_in,
  input logic             out_valid,
  input logic             out_illegal,
  input logic [OUT_W-1:0] out_data
);

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ##2 out_valid);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready, 2));

  a_r6_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode == 2'b11) |-> ##2 out_illegal);

  a_r8_legal_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode != 2'b11) |-> ##2 !out_illegal);

  a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> out_data == $past(acc_in, 2));

  a_r10_flag_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_valid);

endmodule

bind imm_mac imm_mac_chk #(.OUT_W(ROWS*COLS*ACC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .mode        (mode),
  .acc_in      (acc_in),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .out_data    (out_data)
);

// File: tb/imm_mac_test.sv
`timescale 1ns/1ps
module imm_mac_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [1:0]   mode;
  logic [127:0] src_a, src_b, acc_in;
  logic         out_valid, out_illegal;
  logic [127:0] out_data;

  int total  = 0;
  int failed = 0;

  // expected history: [0] = driven last negedge, [1] = two negedges ago
  logic         hv  [2];
  logic         hil [2];
  logic [127:0] hd  [2];
  string        ht  [2];

  always #5 clk = ~clk;

  imm_mac uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .mode        (mode),
    .src_a       (src_a),
    .src_b       (src_b),
    .acc_in      (acc_in),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_data    (out_data)
  );

  function automatic logic [127:0] ref_mac(input logic [1:0] m,
                                           input logic [127:0] a, b, c);
    logic [127:0] r;
    r = c;
    if (m == 2'b11) return c;
    for (int i = 0; i < 2; i++) begin
      for (int j = 0; j < 2; j++) begin
        logic [31:0] s;
        s = c[(2*i+j)*32 +: 32];
        for (int k = 0; k < 8; k++) begin
          logic [7:0] ab, bb;
          int av, bv;
          ab = a[(8*i+k)*8 +: 8];
          bb = b[(8*j+k)*8 +: 8];
          av = (m == 2'b00) ? int'($signed(ab)) : int'(ab);
          bv = (m == 2'b01) ? int'(bb) : int'($signed(bb));
          s = s + 32'(av * bv);
        end
        r[(2*i+j)*32 +: 32] = s;
      end
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid === hv[1], hv[1] ? "R7" : "R8", "out_valid",
        128'(out_valid), 128'(hv[1]));
    chk(out_illegal === (hv[1] && hil[1]), (hv[1] && hil[1]) ? "R6" : "R10",
        "out_illegal", 128'(out_illegal), 128'(hv[1] && hil[1]));
    if (hv[1])
      chk(out_data === hd[1], ht[1], "out_data", out_data, hd[1]);
  endtask

  task automatic clear_hist();
    for (int n = 0; n < 2; n++) begin
      hv[n] = 1'b0; hil[n] = 1'b0; hd[n] = '0; ht[n] = "";
    end
  endtask

  task automatic step(input logic v, input logic [1:0] m,
                      input logic [127:0] a, b, c, input string tag);
    @(negedge clk);
    compare();
    hv[1] = hv[0]; hil[1] = hil[0]; hd[1] = hd[0]; ht[1] = ht[0];
    hv[0]  = v && in_ready;
    hil[0] = (m == 2'b11);
    hd[0]  = ref_mac(m, a, b, c);
    ht[0]  = tag;
    in_valid = v; mode = m; src_a = a; src_b = b; acc_in = c;
  endtask

  task automatic idle(input int n);
    for (int q = 0; q < n; q++) step(1'b0, 2'b00, '0, '0, '0, "R8");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b1;
    clear_hist();
    for (int q = 0; q < 3; q++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R9", "out_valid in reset", 128'(out_valid), '0);
      chk(out_illegal === 1'b0, "R9", "out_illegal in reset", 128'(out_illegal), '0);
      chk(in_ready === 1'b0, "R9", "in_ready in reset", 128'(in_ready), '0);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R9", "in_ready after release", 128'(in_ready), 128'(1));
  endtask

  initial begin
    #2_000_000;
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    logic [127:0] a, b;
    rst_n = 1'b1; in_valid = 1'b0; mode = 2'b00;
    src_a = '0; src_b = '0; acc_in = '0;
    clear_hist();
    #2 rst_n = 1'b0;
    do_reset();
    idle(2);

    // R1: layout with distinct bytes and sparse selectors
    for (int n = 0; n < 16; n++) a[n*8 +: 8] = 8'(n + 1);
    b = '0; b[0*8 +: 8] = 8'd1; b[9*8 +: 8] = 8'd2;
    step(1'b1, 2'b01, a, b,
         {32'd4000, 32'd3000, 32'd2000, 32'd1000}, "R1");
    b = '0; b[7*8 +: 8] = 8'd3; b[12*8 +: 8] = 8'd5;
    step(1'b1, 2'b00, a, b, '0, "R1");

    // R5: wrap in both directions
    step(1'b1, 2'b01, {16{8'hFF}}, {16{8'hFF}}, {4{32'hFFFF_FFFF}}, "R5");
    step(1'b1, 2'b10, {16{8'hFF}}, {16{8'h80}}, '0, "R5");
    step(1'b1, 2'b00, {16{8'h80}}, {16{8'h80}}, {4{32'h7FFF_FFF0}}, "R5");
    idle(1);

    // back-to-back per mode, then reserved mode between legal ones
    for (int m = 0; m < 3; m++)
      for (int q = 0; q < 6; q++)
        step(1'b1, 2'(m), rnd128(), rnd128(), rnd128(), tag_of(2'(m)));
    step(1'b1, 2'b00, rnd128(), rnd128(), rnd128(), "R2");
    step(1'b1, 2'b11, rnd128(), rnd128(), rnd128(), "R6");
    step(1'b1, 2'b10, rnd128(), rnd128(), rnd128(), "R4");
    idle(1);
    step(1'b1, 2'b11, {16{8'h80}}, {16{8'h7F}}, rnd128(), "R6");
    idle(2);

    // mixed traffic with gaps
    for (int q = 0; q < 60; q++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      step(1'($urandom_range(0, 1)), m, rnd128(), rnd128(), rnd128(), tag_of(m));
    end

    // R9: reset with a full pipeline
    step(1'b1, 2'b01, rnd128(), rnd128(), rnd128(), "R3");
    step(1'b1, 2'b11, rnd128(), rnd128(), rnd128(), "R6");
    do_reset();
    idle(2);
    for (int q = 0; q < 8; q++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      step(1'b1, m, rnd128(), rnd128(), rnd128(), tag_of(m));
    end
    idle(3);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule